// File: doc/BRIEF.md
# Performance Monitor Overflow Status Register

This block keeps one sticky overflow flag for each of four event counters and for one cycle counter of a performance monitor. A counter that wraps sends a single-cycle pulse, and the pulse sets that counter's flag. The flag then stays set until software clears it. Software reaches the flags through a simple register bus with read and write strobes. A read returns the flags as a 32-bit word. A write clears every flag whose data bit is 1 (write-one-to-clear).

Each access also carries a mode bit that tells privileged code from user code. A separate user-enable input decides whether user code may touch the register at all. Privileged accesses always complete. A user access made while user-enable is low is refused, and the block raises an error so that the surrounding logic can take an undefined-instruction trap. Read data and the error indication are registered and appear one cycle after the strobe.

Top module: `pmu_ovf_status`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every flag, read data and the error output to 0, and overflow pulses present during reset are not kept.
- R2: An overflow pulse sets its flag. The cycle counter flag is word bit 31, and event counter k (k = 0..3) uses word bit k.
- R3: A set flag stays 1 through idle cycles and reads until a permitted write clears it.
- R4: In a permitted write, each data bit of 1 at a flag position clears that flag, and each data bit of 0 leaves that flag unchanged.
- R5: Reserved word bits 30 down to 4 always read as 0, and writing ones to them has no effect on any flag.
- R6: A privileged access (priv_i = 1) completes whatever the value of usr_en_i.
- R7: A user access (priv_i = 0) while usr_en_i = 0 is refused: err_o is 1 in the cycle after the strobe and only for that cycle, and a refused write changes no flag.
- R8: A refused read drives rdata_o to 0.
- R9: With usr_en_i = 1, user reads and writes behave exactly like privileged ones, and err_o stays 0.
- R10: When an overflow pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: rdata_o shows the flags as they were before the edge of the read strobe, even if a write occurs in the same cycle. The value is valid in the following cycle, and rdata_o is 0 in every cycle that follows a cycle with no permitted read.
- R12: err_o is 0 after any cycle that had no refused access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt_i | input | 4 | Overflow pulses from event counters 3..0 |
| ovf_cyc_i | input | 1 | Overflow pulse from the cycle counter |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data; ones clear flags |
| priv_i | input | 1 | 1 = privileged access, 0 = user access |
| usr_en_i | input | 1 | Allows user accesses when 1 |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered refused-access indication |

## Verification
A wrong flag is visible only through a later read, so the bench compares every read word against a behavioural model. A lost or phantom flag therefore shows up on the first read after the fault. A wrong access decision shows up on err_o and rdata_o one cycle after the strobe. A clear that should not have happened is caught on the next privileged read. The race between a same-cycle set and clear is forced directly, and the result is read back one cycle later.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;
    localparam int unsigned OVF_DATA_W  = 32;
    localparam int unsigned OVF_NUM_EVT = 4;
    localparam int unsigned OVF_CYC_POS = 31;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_GRANT = 2'b01,
        ACC_DENY  = 2'b10
    } acc_kind_e;
endpackage

// File: rtl/pmu_ovf_access.sv
module pmu_ovf_access
    import pmu_ovf_pkg::*;
(
    input  logic      rd_en,
    input  logic      wr_en,
    input  logic      priv,
    input  logic      usr_en,
    output logic      rd_grant,
    output logic      wr_grant,
    output acc_kind_e kind
);
    logic allowed;

    always_comb begin
        allowed  = priv | usr_en;
        rd_grant = rd_en & allowed;
        wr_grant = wr_en & allowed;
        if (!(rd_en | wr_en)) begin
            kind = ACC_NONE;
        end else if (allowed) begin
            kind = ACC_GRANT;
        end else begin
            kind = ACC_DENY;
        end
    end
endmodule

// File: rtl/pmu_ovf_map.sv
module pmu_ovf_map #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned CYC_POS = 31,
    localparam int unsigned NUM_FLAGS = NUM_EVT + 1
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [DATA_W-1:0]    word_in,
    output logic [DATA_W-1:0]    word_out,
    output logic [NUM_FLAGS-1:0] mask_out
);
    localparam int unsigned RSV_LO = NUM_EVT;
    localparam int unsigned RSV_HI = CYC_POS - 1;

    logic unused_rsvd;

    for (genvar b = 0; b < int'(DATA_W); b++) begin : g_word
        if (b < int'(NUM_EVT)) begin : g_evt
            assign word_out[b] = flags[b];
            assign mask_out[b] = word_in[b];
        end else if (b == int'(CYC_POS)) begin : g_cyc
            assign word_out[b]       = flags[NUM_EVT];
            assign mask_out[NUM_EVT] = word_in[b];
        end else begin : g_rsv
            assign word_out[b] = 1'b0;
        end
    end

    assign unused_rsvd = ^word_in[RSV_HI:RSV_LO];
endmodule

// File: rtl/pmu_ovf_flagnext.sv
module pmu_ovf_flagnext #(
    parameter int unsigned NUM_FLAGS = 5
) (
    input  logic [NUM_FLAGS-1:0] flags_q,
    input  logic [NUM_FLAGS-1:0] set_pulse,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic                 clr_en,
    output logic [NUM_FLAGS-1:0] flags_d
);
    for (genvar i = 0; i < int'(NUM_FLAGS); i++) begin : g_flag
        logic kill;
        assign kill       = clr_en & clr_mask[i];
        assign flags_d[i] = set_pulse[i] | (flags_q[i] & ~kill);
    end
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status
    import pmu_ovf_pkg::*;
#(
    parameter int unsigned DATA_W  = OVF_DATA_W,
    parameter int unsigned NUM_EVT = OVF_NUM_EVT,
    parameter int unsigned CYC_POS = OVF_CYC_POS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ovf_evt_i,
    input  logic               ovf_cyc_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               priv_i,
    input  logic               usr_en_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               err_o
);
    localparam int unsigned NUM_FLAGS = NUM_EVT + 1;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic [DATA_W-1:0]    rdata;
        logic                 err;
    } state_t;

    state_t state_d, state_q;

    logic                 rd_grant, wr_grant;
    acc_kind_e            kind;
    logic [DATA_W-1:0]    flag_word;
    logic [NUM_FLAGS-1:0] clr_mask;
    logic [NUM_FLAGS-1:0] set_pulse;
    logic [NUM_FLAGS-1:0] flags_nx;

    assign set_pulse = {ovf_cyc_i, ovf_evt_i};

    pmu_ovf_access u_access (
        .rd_en    (rd_en_i),
        .wr_en    (wr_en_i),
        .priv     (priv_i),
        .usr_en   (usr_en_i),
        .rd_grant (rd_grant),
        .wr_grant (wr_grant),
        .kind     (kind)
    );

    pmu_ovf_map #(
        .DATA_W  (DATA_W),
        .NUM_EVT (NUM_EVT),
        .CYC_POS (CYC_POS)
    ) u_map (
        .flags    (state_q.flags),
        .word_in  (wdata_i),
        .word_out (flag_word),
        .mask_out (clr_mask)
    );

    pmu_ovf_flagnext #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_next (
        .flags_q   (state_q.flags),
        .set_pulse (set_pulse),
        .clr_mask  (clr_mask),
        .clr_en    (wr_grant),
        .flags_d   (flags_nx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flags_nx;
        state_d.rdata = rd_grant ? flag_word : '0;
        state_d.err   = (kind == ACC_DENY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;
    assign err_o   = state_q.err;
endmodule

// File: rtl/pmu_ovf_status_chk.sv
module pmu_ovf_status_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned CYC_POS = 31,
    localparam int unsigned NUM_FLAGS = NUM_EVT + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_EVT-1:0]   ovf_evt_i,
    input logic                 ovf_cyc_i,
    input logic                 rd_en_i,
    input logic                 wr_en_i,
    input logic                 priv_i,
    input logic                 usr_en_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic                 err_o,
    input logic [NUM_FLAGS-1:0] flags_q
);
    logic                 refused;
    logic [NUM_FLAGS-1:0] pulses;

    assign refused = (rd_en_i | wr_en_i) & ~priv_i & ~usr_en_i;
    assign pulses  = {ovf_cyc_i, ovf_evt_i};

    a_r7_deny_err: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> err_o);

    a_r12_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> !err_o);

    a_r8_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i & refused) |=> (rdata_o == '0));

    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> (rdata_o[CYC_POS-1:NUM_EVT] == '0));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != '0) |=> ((flags_q & $past(pulses)) == $past(pulses)));

    a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i & refused) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

bind pmu_ovf_status pmu_ovf_status_chk #(
    .DATA_W  (DATA_W),
    .NUM_EVT (NUM_EVT),
    .CYC_POS (CYC_POS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_evt_i (ovf_evt_i),
    .ovf_cyc_i (ovf_cyc_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .priv_i    (priv_i),
    .usr_en_i  (usr_en_i),
    .rdata_o   (rdata_o),
    .err_o     (err_o),
    .flags_q   (state_q.flags)
);

// File: tb/pmu_ovf_status_test.sv
module pmu_ovf_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ovf_evt_i = '0;
    logic        ovf_cyc_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        priv_i = 1'b1;
    logic        usr_en_i = 1'b0;
    logic [31:0] rdata_o;
    logic        err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int n_edges  = 0;

    logic [31:0] m_flags = '0;
    logic [31:0] m_rdata = '0;
    logic        m_err   = 1'b0;

    localparam logic [31:0] FLAG_BITS = 32'h8000_000F;

    always #2 clk = ~clk;

    pmu_ovf_status uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_evt_i (ovf_evt_i),
        .ovf_cyc_i (ovf_cyc_i),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .priv_i    (priv_i),
        .usr_en_i  (usr_en_i),
        .rdata_o   (rdata_o),
        .err_o     (err_o)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit ok;
        n_edges++;
        if (!rst_n) begin
            m_flags = '0;
            m_rdata = '0;
            m_err   = 1'b0;
        end else begin
            ok      = priv_i || usr_en_i;
            m_rdata = (rd_en_i && ok) ? m_flags : 32'h0;
            m_err   = (rd_en_i || wr_en_i) && !ok;
            if (wr_en_i && ok) m_flags = m_flags & ~(wdata_i & FLAG_BITS);
            m_flags = m_flags | {ovf_cyc_i, 27'h0, ovf_evt_i};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (n_edges > 0) begin
            chk("R11 model rdata", rdata_o, m_rdata);
            chk("R12 model err", {31'h0, err_o}, {31'h0, m_err});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        rd_en_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
        ovf_evt_i = '0; ovf_cyc_i = 1'b0;
    endtask

    task automatic rd(input logic [31:0] exp, input logic exp_err, input string tag);
        rd_en_i = 1'b1;
        tick();
        idle_bus();
        chk(tag, rdata_o, exp);
        chk(tag, {31'h0, err_o}, {31'h0, exp_err});
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en_i = 1'b1; wdata_i = d;
        tick();
        idle_bus();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset with pulses present
        tick();
        ovf_evt_i = 4'hF; ovf_cyc_i = 1'b1;
        tick(); tick();
        idle_bus();
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset rdata", rdata_o, 32'h0);
        chk("R1 reset err", {31'h0, err_o}, 32'h0);
        rd(32'h0, 1'b0, "R1 flags clear after reset");

        // R2: pulses set mapped bits
        ovf_evt_i = 4'h1; ovf_cyc_i = 1'b1;
        tick(); idle_bus();
        rd(32'h8000_0001, 1'b0, "R2 cycle and evt0 flags");

        // R3: sticky
        repeat (5) tick();
        rd(32'h8000_0001, 1'b0, "R3 flags persist");

        // R4 / R5
        wr(32'h0);
        rd(32'h8000_0001, 1'b0, "R4 zero write no effect");
        wr(32'h7FFF_FFF0);
        rd(32'h8000_0001, 1'b0, "R5 reserved write no effect");
        wr(32'h0000_0001);
        rd(32'h8000_0000, 1'b0, "R4 clear evt0 only");

        ovf_evt_i = 4'hA;
        tick(); idle_bus();
        rd(32'h8000_000A, 1'b0, "R2 evt3 and evt1 flags");

        // R7 / R8: user refused
        priv_i = 1'b0; usr_en_i = 1'b0;
        wr(32'hFFFF_FFFF);
        chk("R7 refused write err", {31'h0, err_o}, 32'h1);
        tick();
        chk("R7 err lasts one cycle", {31'h0, err_o}, 32'h0);
        rd(32'h0, 1'b1, "R8 refused read zero");
        priv_i = 1'b1;
        rd(32'h8000_000A, 1'b0, "R7 refused write left flags");

        // R9: user enabled
        priv_i = 1'b0; usr_en_i = 1'b1;
        rd(32'h8000_000A, 1'b0, "R9 user read allowed");
        wr(32'h8000_0000);
        chk("R9 user write no err", {31'h0, err_o}, 32'h0);
        rd(32'h0000_000A, 1'b0, "R9 user write cleared cycle flag");

        // R6: privileged with user-enable low
        priv_i = 1'b1; usr_en_i = 1'b0;
        wr(32'h0000_0002);
        rd(32'h0000_0008, 1'b0, "R6 privileged write with usr_en low");

        // R10: set and clear same cycle
        ovf_evt_i = 4'h4;
        wr(32'h0000_0004);
        rd(32'h0000_000C, 1'b0, "R10 pulse wins over clear");
        ovf_cyc_i = 1'b1;
        wr(32'hFFFF_FFFF);
        rd(32'h8000_0000, 1'b0, "R10 cycle pulse wins over clear all");

        // R11: read sees pre-write value
        rd_en_i = 1'b1; wr_en_i = 1'b1; wdata_i = 32'hFFFF_FFFF;
        tick(); idle_bus();
        chk("R11 read before same-cycle write", rdata_o, 32'h8000_0000);
        rd(32'h0, 1'b0, "R11 write applied after read");
        rd_en_i = 1'b1; ovf_evt_i = 4'h2;
        tick(); idle_bus();
        chk("R11 read before same-cycle pulse", rdata_o, 32'h0);
        tick();
        chk("R11 no read gives zero", rdata_o, 32'h0);
        rd(32'h0000_0002, 1'b0, "R11 pulse visible next read");

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            rd_en_i   = ($urandom % 3) == 0;
            wr_en_i   = ($urandom % 4) == 0;
            wdata_i   = $urandom;
            priv_i    = ($urandom % 2) == 0;
            usr_en_i  = ($urandom % 2) == 0;
            ovf_evt_i = 4'($urandom % 16) & 4'($urandom % 16);
            ovf_cyc_i = ($urandom % 5) == 0;
            tick();
        end
        idle_bus();
        priv_i = 1'b1;
        tick();
        rd(m_flags, 1'b0, "R3 final flags match model");

        // R1: reset after activity
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        rd(32'h0, 1'b0, "R1 reset clears set flags");
        report();
    end
endmodule